// File: doc/BRIEF.md
# Ingress Retry Queue with Per-Destination Sequence Tracking

This block sits on the transmit side of a node, between the fragmenter and the switch link. Every fragment that is offered is written into a slot of a circular store. It is stamped with the next sequence number of its own destination node. The packet is then launched toward the switch. The slot stays occupied after launch and is released only when the link partner returns an acknowledge that names the same destination and sequence number. This retained copy is what gives delivery its guarantee. It also pushes back on the fragmenter when the far side stops acknowledging.

There is no timeout and no negative acknowledge. Retransmission is triggered implicitly. An acknowledge for sequence number S to node D tells the block that every packet to D that was launched earlier than S and is still unacknowledged was lost. Those packets are rescheduled, and they are sent again before any new traffic, oldest first. Each destination has its own sequence space, which wraps. To keep modular ordering unambiguous, each destination may have at most half of that space outstanding.

Top module: `ingress_retry_queue`

## Requirements
- R1: After reset, `tx_valid` and `ack_err` are 0, `enq_ready` is 1, and every destination's next sequence number is 0.
- R2: An accepted fragment is stamped with the current sequence number of its destination. That number then advances by one modulo 2^SEQ_W. Each destination counts independently of the others.
- R3: `tx_valid`, `tx_dest`, `tx_seq` and `tx_data` are registered. A new launch appears one cycle after the cycle in which the output register was empty or was being accepted. Outputs hold steady while `tx_valid`=1 and `tx_ready`=0. The data is exactly the data that was enqueued.
- R4: A slot is freed by an acknowledge whose destination and sequence number equal those of a launched, unacknowledged slot. Freed slots are returned to the store one per cycle, oldest position first. `enq_ready` is 0 while all DEPTH positions from oldest to newest are in use.
- R5: When an acknowledge matches, every other launched slot to the same destination whose sequence number is older is marked for resend. Older means (ack_seq − slot_seq) mod 2^SEQ_W lies in 1 .. 2^(SEQ_W−1)−1. Slots to other destinations, and slots still waiting for their first launch, are not affected.
- R6: Slots marked for resend are launched before any slot awaiting its first launch. Within each class, the oldest enqueued slot goes first.
- R7: An acknowledge that matches no launched, unacknowledged slot changes no slot. It sets `ack_err`, which stays at 1 until reset.
- R8: `enq_ready` is 0 for a destination that already has 2^(SEQ_W−1) accepted but unacknowledged packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Fragment offered |
| enq_ready | output | 1 | Fragment will be taken this cycle |
| enq_dest | input | NODE_W | Destination node of the fragment |
| enq_data | input | DATA_W | Fragment payload |
| tx_valid | output | 1 | Packet presented to the switch |
| tx_ready | input | 1 | Switch takes the packet |
| tx_dest | output | NODE_W | Destination of the presented packet |
| tx_seq | output | SEQ_W | Sequence number of the presented packet |
| tx_data | output | DATA_W | Payload of the presented packet |
| ack_valid | input | 1 | Acknowledge present |
| ack_dest | input | NODE_W | Destination named by the acknowledge |
| ack_seq | input | SEQ_W | Sequence number named by the acknowledge |
| ack_err | output | 1 | Sticky flag for an acknowledge that matched nothing |

## Verification
The bench runs with a 3-bit sequence space, two destinations and eight slots. In that setting the wrap point, the per-destination window and a full store are all reached many times. Acknowledges are often drawn from a packet that is not the oldest outstanding one, which forces retransmissions behind it. A design that compared sequence numbers without the modular wrap would resend the wrong packets, and `tx_seq` would differ. A design that let new traffic overtake resends would show up in `tx_dest` and `tx_data`. The bench also sends acknowledges that do not match any launched slot, and it stalls the switch side for long stretches. A block that freed a slot on a bogus acknowledge, or that dropped a held packet, diverges from the model's `enq_ready` or output stream.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // lifecycle of one slot in the retry store
  typedef enum logic [1:0] {
    ST_PEND = 2'd0,  // waiting for first launch
    ST_SENT = 2'd1,  // launched, awaiting acknowledge
    ST_RTY  = 2'd2   // launched, then found lost; resend pending
  } slot_st_e;
endpackage

// File: rtl/rq_seq_track.sv
module rq_seq_track #(
  parameter int NODES  = 16,
  parameter int NODE_W = 4,
  parameter int SEQ_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_fire,
  input  logic [NODE_W-1:0] enq_dest,
  input  logic              ack_hit,
  input  logic [NODE_W-1:0] ack_dest,
  output logic [SEQ_W-1:0]  cur_seq,
  output logic              room
);
  localparam int WIN = 1 << (SEQ_W - 1);

  logic [SEQ_W-1:0] next_seq [NODES];
  logic [SEQ_W-1:0] live     [NODES];

  assign cur_seq = next_seq[enq_dest];
  assign room    = live[enq_dest] < SEQ_W'(WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NODES; n++) begin
        next_seq[n] <= '0;
        live[n]     <= '0;
      end
    end else begin
      for (int n = 0; n < NODES; n++) begin
        if (enq_fire && enq_dest == NODE_W'(n)) next_seq[n] <= next_seq[n] + 1'b1;
        if ((enq_fire && enq_dest == NODE_W'(n)) && !(ack_hit && ack_dest == NODE_W'(n)))
          live[n] <= live[n] + 1'b1;
        else if (!(enq_fire && enq_dest == NODE_W'(n)) && (ack_hit && ack_dest == NODE_W'(n)))
          live[n] <= live[n] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NODES; g++) begin : g_chk
    // R8: outstanding count per destination never exceeds half the sequence space
    a_r8_window: assert property (@(posedge clk) disable iff (rst) live[g] <= SEQ_W'(WIN));
  end
endmodule

// File: rtl/rq_pick.sv
module rq_pick #(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] head,
  input  logic [DEPTH-1:0] rty_m,
  input  logic [DEPTH-1:0] pend_m,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] j;
  logic             rfound;
  logic [IDX_W-1:0] ridx, pidx;
  logic             pfound;

  // scan from youngest to oldest so the oldest hit is written last
  always_comb begin
    j = '0; rfound = 1'b0; ridx = '0; pfound = 1'b0; pidx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      j = head + IDX_W'(k);
      if (rty_m[j])  begin rfound = 1'b1; ridx = j; end
      if (pend_m[j]) begin pfound = 1'b1; pidx = j; end
    end
  end

  assign found = rfound | pfound;
  assign idx   = rfound ? ridx : pidx;
endmodule

// File: rtl/ingress_retry_queue.sv
module ingress_retry_queue
  import rq_pkg::*;
#(
  parameter int DEPTH  = 256,  // power of two
  parameter int NODES  = 16,
  parameter int SEQ_W  = 6,
  parameter int DATA_W = 32,
  parameter int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [NODE_W-1:0] enq_dest,
  input  logic [DATA_W-1:0] enq_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [NODE_W-1:0] tx_dest,
  output logic [SEQ_W-1:0]  tx_seq,
  output logic [DATA_W-1:0] tx_data,
  input  logic              ack_valid,
  input  logic [NODE_W-1:0] ack_dest,
  input  logic [SEQ_W-1:0]  ack_seq,
  output logic              ack_err
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  slot_v;
  slot_st_e          slot_st   [DEPTH];
  logic [NODE_W-1:0] slot_dest [DEPTH];
  logic [SEQ_W-1:0]  slot_seq  [DEPTH];
  logic [IDX_W-1:0]  head, tail, pick;
  logic [IDX_W:0]    used;
  logic [DEPTH-1:0]  rty_m, pend_m, hit_v, old_v;
  logic [SEQ_W-1:0]  cur_seq;
  logic              room, found, launch, reclaim, ack_hit, enq_fire;

  assign enq_ready = (used != (IDX_W+1)'(DEPTH)) && room;
  assign enq_fire  = enq_valid && enq_ready;
  assign ack_hit   = |hit_v;
  assign launch    = found && (!tx_valid || tx_ready);
  assign reclaim   = (used != '0) && !slot_v[head];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [SEQ_W-1:0] sdiff;
    assign sdiff     = ack_seq - slot_seq[i];
    assign rty_m[i]  = slot_v[i] && slot_st[i] == ST_RTY;
    assign pend_m[i] = slot_v[i] && slot_st[i] == ST_PEND;
    assign hit_v[i]  = ack_valid && slot_v[i] && slot_st[i] != ST_PEND &&
                       slot_dest[i] == ack_dest && slot_seq[i] == ack_seq;
    assign old_v[i]  = slot_v[i] && slot_st[i] == ST_SENT && slot_dest[i] == ack_dest &&
                       sdiff != '0 && !sdiff[SEQ_W-1];
  end

  rq_seq_track #(.NODES(NODES), .NODE_W(NODE_W), .SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst(rst), .enq_fire(enq_fire), .enq_dest(enq_dest),
    .ack_hit(ack_hit), .ack_dest(ack_dest), .cur_seq(cur_seq), .room(room)
  );

  rq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .head(head), .rty_m(rty_m), .pend_m(pend_m), .found(found), .idx(pick)
  );

  // payload store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (enq_fire) mem[tail] <= enq_data;
    if (launch)   tx_data   <= mem[pick];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        slot_v[i]  <= 1'b0;
        slot_st[i] <= ST_PEND;
      end
      head <= '0; tail <= '0; used <= '0;
      tx_valid <= 1'b0; tx_dest <= '0; tx_seq <= '0; ack_err <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (launch && pick == IDX_W'(i)) slot_st[i] <= ST_SENT;
        if (ack_hit && old_v[i])         slot_st[i] <= ST_RTY;
        if (hit_v[i])                    slot_v[i]  <= 1'b0;
      end
      if (enq_fire) begin
        slot_v[tail]    <= 1'b1;
        slot_st[tail]   <= ST_PEND;
        slot_dest[tail] <= enq_dest;
        slot_seq[tail]  <= cur_seq;
        tail            <= tail + 1'b1;
      end
      if (reclaim) head <= head + 1'b1;
      used <= used + {{IDX_W{1'b0}}, enq_fire} - {{IDX_W{1'b0}}, reclaim};
      if (launch) begin
        tx_valid <= 1'b1;
        tx_dest  <= slot_dest[pick];
        tx_seq   <= slot_seq[pick];
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      if (ack_valid && !ack_hit) ack_err <= 1'b1;
    end
  end

  // R4: occupancy never passes capacity
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst) used <= (IDX_W+1)'(DEPTH));
  // R3: a stalled packet is held unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_seq) && $stable(tx_dest));
  // R6: when any resend is pending the picker chooses a resend
  a_r6_resend_first: assert property (@(posedge clk) disable iff (rst) (|rty_m) |-> rty_m[pick]);
  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst) ack_err |=> ack_err);
endmodule

// File: tb/ingress_retry_queue_bench.sv
module ingress_retry_queue_bench;
  localparam int DEPTH = 8, NODES = 2, SEQ_W = 3, DATA_W = 16, NODE_W = 1;
  localparam int SPACE = 1 << SEQ_W, WIN = SPACE / 2;
  localparam int PEND = 0, SENT = 1, RTY = 2;

  logic clk = 0, rst = 1;
  logic enq_valid = 0, tx_ready = 0, ack_valid = 0;
  logic [NODE_W-1:0] enq_dest = '0, ack_dest = '0;
  logic [DATA_W-1:0] enq_data = '0;
  logic [SEQ_W-1:0]  ack_seq = '0;
  logic enq_ready, tx_valid, ack_err;
  logic [NODE_W-1:0] tx_dest;
  logic [SEQ_W-1:0]  tx_seq;
  logic [DATA_W-1:0] tx_data;

  always #2.5 clk = ~clk;

  ingress_retry_queue #(.DEPTH(DEPTH), .NODES(NODES), .SEQ_W(SEQ_W), .DATA_W(DATA_W))
  u_ingress_retry_queue (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_dest(enq_dest),
    .enq_data(enq_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dest(tx_dest),
    .tx_seq(tx_seq), .tx_data(tx_data), .ack_valid(ack_valid), .ack_dest(ack_dest),
    .ack_seq(ack_seq), .ack_err(ack_err)
  );

  typedef struct { bit v; int dest; int seq; int st; int data; } rec_t;
  rec_t q[$];
  int nseq[NODES], live[NODES];
  int e_valid = 0, e_dest = 0, e_seq = 0, e_data = 0, e_err = 0;
  int vectors = 0, fails = 0, resends = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit older(int a, int s);
    int d = (a - s + SPACE) % SPACE;
    return d != 0 && d < WIN;
  endfunction

  function automatic bit model_ready(int d);
    return q.size() < DEPTH && live[d] < WIN;
  endfunction

  task automatic model_step();
    int cand = -1, hitk = -1;
    bit fire, launch, pop;
    bit mark[$];
    fire = enq_valid && model_ready(int'(enq_dest));
    for (int k = 0; k < q.size(); k++) if (cand < 0 && q[k].v && q[k].st == RTY) cand = k;
    for (int k = 0; k < q.size(); k++) if (cand < 0 && q[k].v && q[k].st == PEND) cand = k;
    launch = cand >= 0 && (e_valid == 0 || tx_ready);
    if (ack_valid)
      for (int k = 0; k < q.size(); k++)
        if (q[k].v && q[k].st != PEND && q[k].dest == int'(ack_dest) && q[k].seq == int'(ack_seq))
          hitk = k;
    for (int k = 0; k < q.size(); k++)
      mark.push_back(hitk >= 0 && q[k].v && q[k].st == SENT && q[k].dest == int'(ack_dest) &&
                     older(int'(ack_seq), q[k].seq));
    pop = q.size() > 0 && !q[0].v;
    if (launch) begin
      if (q[cand].st == RTY) resends++;
      e_valid = 1; e_dest = q[cand].dest; e_seq = q[cand].seq; e_data = q[cand].data;
      q[cand].st = SENT;
    end else if (tx_ready) e_valid = 0;
    for (int k = 0; k < q.size(); k++) if (mark[k]) q[k].st = RTY;
    if (hitk >= 0) begin q[hitk].v = 0; live[int'(ack_dest)]--; end
    if (ack_valid && hitk < 0) e_err = 1;
    if (pop) void'(q.pop_front());
    if (fire) begin
      q.push_back('{1'b1, int'(enq_dest), nseq[int'(enq_dest)], PEND, int'(enq_data)});
      nseq[int'(enq_dest)] = (nseq[int'(enq_dest)] + 1) % SPACE;
      live[int'(enq_dest)]++;
    end
  endtask

  task automatic drive(int p_enq, int p_ack, int p_rdy);
    int outs[$];
    enq_valid = ($urandom % 100) < p_enq;
    enq_dest  = NODE_W'($urandom % NODES);
    enq_data  = DATA_W'($urandom);
    tx_ready  = ($urandom % 100) < p_rdy;
    ack_valid = ($urandom % 100) < p_ack;
    for (int k = 0; k < q.size(); k++) if (q[k].v && q[k].st != PEND) outs.push_back(k);
    if (outs.size() > 0 && ($urandom % 100) < 85) begin
      int k = outs[$urandom % outs.size()];
      ack_dest = NODE_W'(q[k].dest);
      ack_seq  = SEQ_W'(q[k].seq);
    end else begin
      ack_dest = NODE_W'($urandom % NODES);
      ack_seq  = SEQ_W'($urandom % SPACE);
    end
  endtask

  task automatic cycle(int p_enq, int p_ack, int p_rdy);
    @(negedge clk);
    chk("R3/R6 tx_valid", int'(tx_valid), e_valid);
    if (e_valid != 0) begin
      chk("R3/R6 tx_dest", int'(tx_dest), e_dest);
      chk("R2/R5 tx_seq", int'(tx_seq), e_seq);
      chk("R3 tx_data", int'(tx_data), e_data);
    end
    chk("R7 ack_err", int'(ack_err), e_err);
    drive(p_enq, p_ack, p_rdy);
    #1;
    chk("R4/R8 enq_ready", int'(enq_ready), int'(model_ready(int'(enq_dest))));
    model_step();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < NODES; n++) begin nseq[n] = 0; live[n] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state visible before any stimulus
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 ack_err", int'(ack_err), 0);
    chk("R1 enq_ready", int'(enq_ready), 1);
    model_step();
    // fill with acks withheld: store and window limits (R4, R8), sequence from 0 (R2)
    for (int c = 0; c < 40; c++) cycle(90, 0, 100);
    // stalled switch side (R3)
    for (int c = 0; c < 60; c++) cycle(70, 30, 10);
    // mixed traffic: skipping acks force resends (R5, R6), wrap of sequence (R2)
    for (int c = 0; c < 3000; c++) cycle(60, 45, 75);
    // drain
    for (int c = 0; c < 300; c++) cycle(0, 70, 100);
    chk("R5 resend observed", int'(resends > 0), 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule